// File: doc/BRIEF.md
# Codec Power Mode Controller

This block decides the operating state of a voice codec's digital section. It runs on the system clock and watches four asynchronous inputs: an active-low power-down request, the serial bit clock, the transmit frame sync and the receive frame sync. From them it reports one of three states and drives the enables of the transmit path, the receive path and the serial output driver.

The power-down request always wins. If it is not asserted, the block counts system clock cycles since the last level change of the bit clock and of the transmit frame sync. When either count reaches its timeout, the codec drops to power-save. The level at which the line stopped does not matter. A missing receive frame sync never changes the state. To return to normal operation, both watched lines must show a rise and a fall. Normal operation then resumes on the next rising edge of the transmit frame sync, so the transmit timing starts again at a frame boundary.

The block also decodes a test input that selects loop-back routing, where the receive path output feeds the transmit path input. It forwards receive frame starts as one-cycle strobes while the codec is operating normally.

Top module: `codec_pwr_ctl`

## Requirements
- R1: Two system clock cycles after `pd_ctl_n` is sampled low, `pwr_state` reads 2'b10 (power-down), and it stays 2'b10 while the input stays low.
- R2: While in power-down, activity or silence on `ser_clk`, `tx_fsync` and `rx_fsync` has no effect on `pwr_state`.
- R3: In normal state (2'b00), if `ser_clk` shows no level change for `BCLK_TIMEOUT` system cycles, `pwr_state` becomes 2'b01 (power-save). This holds whether the clock is stuck high or stuck low.
- R4: In normal state, if `tx_fsync` shows no level change for `SYNC_TIMEOUT` system cycles, `pwr_state` becomes 2'b01. This holds whether the sync is stuck high or stuck low.
- R5: Presence or absence of `rx_fsync` never changes `pwr_state`.
- R6: `tx_path_en`, `rx_path_en` and `ser_out_en` are high exactly when `pwr_state` is 2'b00. The serial output is therefore disabled (high-impedance) in both power-save and power-down.
- R7: Power-save is left for normal only on a synchronized rising edge of `tx_fsync`. That edge must come after a rise and a fall of `ser_clk` and a rise and a fall of `tx_fsync` have all been seen in power-save, and while neither timeout has expired.
- R8: Leaving power-down always passes through power-save (2'b01), never straight to normal.
- R9: `loop_sel` is high exactly when the synchronized `test_loop` input is 1 and `pwr_state` is 2'b00. A value of 0 selects normal routing.
- R10: `rx_frame_strobe` pulses high for one cycle per synchronized rising edge of `rx_fsync`, only in normal state.
- R11: During and right after reset, `pwr_state` is 2'b10 and all enables and strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_ctl_n | input | 1 | Power-down request, active low, asynchronous |
| ser_clk | input | 1 | Serial bit clock, sampled as data |
| tx_fsync | input | 1 | Transmit frame sync, sampled |
| rx_fsync | input | 1 | Receive frame sync, sampled |
| test_loop | input | 1 | 1 selects loop-back routing, 0 selects normal routing |
| pwr_state | output | 2 | 00 normal, 01 power-save, 10 power-down |
| tx_path_en | output | 1 | Transmit path enable |
| rx_path_en | output | 1 | Receive path enable |
| ser_out_en | output | 1 | Serial output driver enable |
| loop_sel | output | 1 | Loop-back routing select |
| rx_frame_strobe | output | 1 | One-cycle receive frame start |

## Verification
A wrong internal state shows at once, in the same cycle, on `pwr_state` and on the three enables, because all of them are decoded directly from the state register. A wrong idle counter or transition flag stays hidden until it matters. A late or early timeout shows as the power-save entry cycle moving, and a bad flag shows as a return to normal on the wrong frame sync edge. The bench therefore compares every output against a behavioural model on every cycle. It also stops each watched line at both levels, so that a count off by a single cycle is caught where it first diverges.

// File: rtl/codec_pwr_ctl.sv
module codec_pwr_ctl #(
  parameter int BCLK_TIMEOUT = 1024,
  parameter int SYNC_TIMEOUT = 12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_ctl_n,
  input  logic       ser_clk,
  input  logic       tx_fsync,
  input  logic       rx_fsync,
  input  logic       test_loop,
  output logic [1:0] pwr_state,
  output logic       tx_path_en,
  output logic       rx_path_en,
  output logic       ser_out_en,
  output logic       loop_sel,
  output logic       rx_frame_strobe
);
  localparam int BW = $clog2(BCLK_TIMEOUT + 1);
  localparam int XW = $clog2(SYNC_TIMEOUT + 1);
  localparam logic [BW-1:0] BMAX = BW'(BCLK_TIMEOUT);
  localparam logic [XW-1:0] XMAX = XW'(SYNC_TIMEOUT);
  localparam logic [1:0] ST_NORM = 2'b00;
  localparam logic [1:0] ST_SAVE = 2'b01;
  localparam logic [1:0] ST_PDWN = 2'b10;

  logic [2:0] b_p, x_p, r_p;
  logic [1:0] pd_p, tm_p;
  logic [BW-1:0] b_cnt;
  logic [XW-1:0] x_cnt;
  logic [1:0] state;
  logic seen_brise, seen_bfall, seen_xrise, seen_xfall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_p  <= '0;
      x_p  <= '0;
      r_p  <= '0;
      pd_p <= '0;
      tm_p <= '0;
    end else begin
      b_p  <= {b_p[1:0], ser_clk};
      x_p  <= {x_p[1:0], tx_fsync};
      r_p  <= {r_p[1:0], rx_fsync};
      pd_p <= {pd_p[0], pd_ctl_n};
      tm_p <= {tm_p[0], test_loop};
    end
  end

  logic pd_s, tm_s, b_edge, b_rise, b_fall, x_edge, x_rise, x_fall, r_rise;
  logic b_dead, x_dead, armed;

  assign pd_s   = pd_p[1];
  assign tm_s   = tm_p[1];
  assign b_edge = b_p[1] ^ b_p[2];
  assign b_rise = b_p[1] & ~b_p[2];
  assign b_fall = ~b_p[1] & b_p[2];
  assign x_edge = x_p[1] ^ x_p[2];
  assign x_rise = x_p[1] & ~x_p[2];
  assign x_fall = ~x_p[1] & x_p[2];
  assign r_rise = r_p[1] & ~r_p[2];
  assign b_dead = (b_cnt == BMAX);
  assign x_dead = (x_cnt == XMAX);
  assign armed  = seen_brise & seen_bfall & seen_xrise & seen_xfall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_cnt <= '0;
      x_cnt <= '0;
    end else begin
      if (b_edge)      b_cnt <= '0;
      else if (!b_dead) b_cnt <= b_cnt + 1'b1;
      if (x_edge)      x_cnt <= '0;
      else if (!x_dead) x_cnt <= x_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_brise <= 1'b0;
      seen_bfall <= 1'b0;
      seen_xrise <= 1'b0;
      seen_xfall <= 1'b0;
    end else if (state != ST_SAVE) begin
      seen_brise <= 1'b0;
      seen_bfall <= 1'b0;
      seen_xrise <= 1'b0;
      seen_xfall <= 1'b0;
    end else begin
      seen_brise <= seen_brise | b_rise;
      seen_bfall <= seen_bfall | b_fall;
      seen_xrise <= seen_xrise | x_rise;
      seen_xfall <= seen_xfall | x_fall;
    end
  end

  logic [1:0] state_nx;
  always_comb begin
    state_nx = state;
    if (!pd_s) state_nx = ST_PDWN;
    else begin
      unique case (state)
        ST_PDWN: state_nx = ST_SAVE;
        ST_NORM: if (b_dead | x_dead) state_nx = ST_SAVE;
        ST_SAVE: if (armed & x_rise & ~b_dead & ~x_dead) state_nx = ST_NORM;
        default: state_nx = ST_PDWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_PDWN;
    else        state <= state_nx;
  end

  logic run;
  assign run             = (state == ST_NORM);
  assign pwr_state       = state;
  assign tx_path_en      = run;
  assign rx_path_en      = run;
  assign ser_out_en      = run;
  assign loop_sel        = run & tm_s;
  assign rx_frame_strobe = run & r_rise;
endmodule

module codec_pwr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwr_state,
  input logic       tx_path_en,
  input logic       ser_out_en,
  input logic       loop_sel,
  input logic       rx_frame_strobe,
  input logic       pd_s,
  input logic       tm_s,
  input logic       b_dead,
  input logic       x_dead,
  input logic       x_rise
);
  assert_pdown_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_s |=> pwr_state == 2'b10);
  assert_pd_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'b10 && pwr_state != 2'b10) |-> pwr_state == 2'b01);
  assert_save_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'b00 && pwr_state == 2'b01) |-> ($past(b_dead) || $past(x_dead)));
  assert_save_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'b01 && pwr_state == 2'b00) |-> $past(x_rise));
  assert_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_path_en || ser_out_en) |-> pwr_state == 2'b00);
  assert_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_sel |-> tm_s);
  assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_strobe |=> !rx_frame_strobe);
  assert_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11);
endmodule

bind codec_pwr_ctl codec_pwr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .tx_path_en(tx_path_en),
  .ser_out_en(ser_out_en), .loop_sel(loop_sel), .rx_frame_strobe(rx_frame_strobe),
  .pd_s(pd_s), .tm_s(tm_s), .b_dead(b_dead), .x_dead(x_dead), .x_rise(x_rise)
);

// File: tb/tb_codec_pwr_ctl.sv
`timescale 1ns/1ps
module tb_codec_pwr_ctl;
  localparam int BTO = 40;
  localparam int XTO = 200;

  logic clk = 0, rst_n = 0, pd_ctl_n = 0, ser_clk = 0, tx_fsync = 0, rx_fsync = 0, test_loop = 0;
  logic [1:0] pwr_state;
  logic tx_path_en, rx_path_en, ser_out_en, loop_sel, rx_frame_strobe;

  codec_pwr_ctl #(.BCLK_TIMEOUT(BTO), .SYNC_TIMEOUT(XTO)) dut (
    .clk(clk), .rst_n(rst_n), .pd_ctl_n(pd_ctl_n), .ser_clk(ser_clk), .tx_fsync(tx_fsync),
    .rx_fsync(rx_fsync), .test_loop(test_loop), .pwr_state(pwr_state), .tx_path_en(tx_path_en),
    .rx_path_en(rx_path_en), .ser_out_en(ser_out_en), .loop_sel(loop_sel),
    .rx_frame_strobe(rx_frame_strobe));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // stimulus generators
  bit b_run = 0, x_run = 0, r_run = 0;
  logic b_lvl = 0, x_lvl = 0, r_lvl = 0;
  int tick = 0;
  initial forever begin
    @(negedge clk);
    tick++;
    ser_clk  <= b_run ? logic'((tick / 4) % 2) : b_lvl;
    tx_fsync <= x_run ? logic'((tick % 128) < 8) : x_lvl;
    rx_fsync <= r_run ? logic'(((tick + 40) % 128) < 8) : r_lvl;
  end

  // behavioural reference model
  int m_bq[$], m_xq[$], m_rq[$], m_pq[$], m_tq[$];
  int m_bidle = 0, m_xidle = 0, m_st = 2;
  int m_seen = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_bq = '{0,0,0}; m_xq = '{0,0,0}; m_rq = '{0,0,0}; m_pq = '{0,0}; m_tq = '{0,0};
      m_bidle = 0; m_xidle = 0; m_st = 2; m_seen = 0;
    end else begin
      int bnew, xnew, bchg, xchg, xup;
      bnew = m_bq[1]; xnew = m_xq[1];
      bchg = (m_bq[1] != m_bq[2]); xchg = (m_xq[1] != m_xq[2]);
      xup  = (m_xq[1] == 1 && m_xq[2] == 0);
      if (m_pq[1] == 0) m_st = 2;
      else if (m_st == 2) m_st = 1;
      else if (m_st == 0) begin
        if (m_bidle == BTO || m_xidle == XTO) m_st = 1;
      end else begin
        if (m_seen == 15 && xup && m_bidle != BTO && m_xidle != XTO) m_st = 0;
        else begin
          if (bchg) m_seen |= (bnew ? 1 : 2);
          if (xchg) m_seen |= (xnew ? 4 : 8);
        end
      end
      if (m_st != 1) m_seen = 0;
      m_bidle = bchg ? 0 : (m_bidle == BTO ? BTO : m_bidle + 1);
      m_xidle = xchg ? 0 : (m_xidle == XTO ? XTO : m_xidle + 1);
      void'(m_bq.pop_back()); m_bq.push_front(int'(ser_clk));
      void'(m_xq.pop_back()); m_xq.push_front(int'(tx_fsync));
      void'(m_rq.pop_back()); m_rq.push_front(int'(rx_fsync));
      void'(m_pq.pop_back()); m_pq.push_front(int'(pd_ctl_n));
      void'(m_tq.pop_back()); m_tq.push_front(int'(test_loop));
    end
  end

  // per-cycle comparison, away from the active edge
  initial forever begin
    @(negedge clk);
    cycles++;
    if (rst_n && cycles > 2) begin
      int en, lp, fr;
      en = (m_st == 0);
      lp = en && m_tq[1] == 1;
      fr = en && m_rq[1] == 1 && m_rq[2] == 0;
      if (pwr_state != 2'(m_st)) chk(0, "R3/R4/R7 state", pwr_state, m_st);
      if (tx_path_en != en || rx_path_en != en || ser_out_en != en)
        chk(0, "R6 enables", {tx_path_en, rx_path_en, ser_out_en}, en ? 7 : 0);
      if (loop_sel != lp) chk(0, "R9 loop", loop_sel, lp);
      if (rx_frame_strobe != fr) chk(0, "R10 strobe", rx_frame_strobe, fr);
      checks++;
    end
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      chk(0, "watchdog", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  int strobes;
  initial begin
    wt(4);
    chk(pwr_state == 2'b10, "R11 reset state", pwr_state, 2);
    chk({tx_path_en, rx_path_en, ser_out_en, loop_sel, rx_frame_strobe} == 0, "R11 outputs", tx_path_en, 0);
    rst_n = 1;
    wt(3);
    chk(pwr_state == 2'b10, "R11 after reset", pwr_state, 2);
    pd_ctl_n = 1; b_run = 1; x_run = 1; r_run = 1;
    wt(4);
    chk(pwr_state == 2'b01, "R8 via save", pwr_state, 1);
    wt(600);
    chk(pwr_state == 2'b00, "R7 normal", pwr_state, 0);
    chk(ser_out_en && tx_path_en && rx_path_en, "R6 enables on", ser_out_en, 1);
    strobes = 0;
    repeat (512) begin @(negedge clk); strobes += rx_frame_strobe; end
    chk(strobes == 4, "R10 strobe count", strobes, 4);
    test_loop = 1; wt(4);
    chk(loop_sel == 1, "R9 loop on", loop_sel, 1);
    test_loop = 0; wt(4);
    chk(loop_sel == 0, "R9 loop off", loop_sel, 0);
    r_run = 0; r_lvl = 0; wt(1000);
    chk(pwr_state == 2'b00, "R5 rx sync absent low", pwr_state, 0);
    r_lvl = 1; wt(1000);
    chk(pwr_state == 2'b00, "R5 rx sync absent high", pwr_state, 0);
    r_run = 1;
    b_lvl = 1; b_run = 0; wt(200);
    chk(pwr_state == 2'b01, "R3 clock stuck high", pwr_state, 1);
    chk(ser_out_en == 0, "R6 output off in save", ser_out_en, 0);
    b_run = 1; wt(600);
    chk(pwr_state == 2'b00, "R7 resume", pwr_state, 0);
    b_lvl = 0; b_run = 0; wt(200);
    chk(pwr_state == 2'b01, "R3 clock stuck low", pwr_state, 1);
    b_run = 1; wt(600);
    chk(pwr_state == 2'b00, "R7 resume 2", pwr_state, 0);
    x_lvl = 0; x_run = 0; wt(400);
    chk(pwr_state == 2'b01, "R4 sync stuck low", pwr_state, 1);
    x_run = 1; wt(600);
    chk(pwr_state == 2'b00, "R7 resume 3", pwr_state, 0);
    x_lvl = 1; x_run = 0; wt(400);
    chk(pwr_state == 2'b01, "R4 sync stuck high", pwr_state, 1);
    x_run = 1; wt(600);
    chk(pwr_state == 2'b00, "R7 resume 4", pwr_state, 0);
    pd_ctl_n = 0; wt(3);
    chk(pwr_state == 2'b10, "R1 power-down", pwr_state, 2);
    chk(ser_out_en == 0 && loop_sel == 0, "R6 output off in pdown", ser_out_en, 0);
    b_run = 0; x_run = 0; wt(500);
    chk(pwr_state == 2'b10, "R2 pdown with lines stopped", pwr_state, 2);
    b_run = 1; x_run = 1; wt(600);
    chk(pwr_state == 2'b10, "R2 pdown with lines running", pwr_state, 2);
    pd_ctl_n = 1; wt(4);
    chk(pwr_state == 2'b01, "R8 exit through save", pwr_state, 1);
    wt(600);
    chk(pwr_state == 2'b00, "R7 normal after pdown", pwr_state, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule